// File: doc/BRIEF.md
# Link Error Threshold Monitor with Interrupt Combining

This block watches one serial port for two kinds of trouble. Link error events arrive as single-cycle pulses and drive a saturating error-rate counter. The counter is compared against two programmable levels, one that marks the link as degraded and one that marks it as failed. Either level set to zero turns its comparison off. Logical/transport error causes arrive as a vector of pulses. They are held in a sticky detect register and qualified by a per-cause enable register. The qualified result is the logical/transport error status.

The three status outputs each pass through their own interrupt enable bit in a control register. The gated results are then ORed into one level-sensitive maintenance interrupt. Software reaches every register through a word-aligned byte-address read/write port. Reads are combinational. The detect register is cleared only by a write of zero, and the error-rate counter is cleared by any write to its address. The reset input is asynchronous and active low, and it is released synchronously inside the block.

Top module: `err_thresh_mon`

## Requirements
- R1: While reset is active and after it is released, every output is 0 and every readable register reads 0.
- R2: Each cycle with `rate_evt` high raises the error-rate counter by one. The counter stops at 255. It reads back in bits [7:0] at address 0x408.
- R3: `port_failed` is 1 in the cycle after one in which the failed level (bits [31:24] at address 0x36C) is non-zero and the counter is at or above it; otherwise it is 0.
- R4: `port_degraded` is 1 in the cycle after one in which the degraded level (bits [23:16] at address 0x36C) is non-zero and the counter is at or above it; otherwise it is 0.
- R5: A level of zero keeps its status output at 0 whatever the counter holds.
- R6: Any write to address 0x408 sets the counter to 0. This takes priority over a `rate_evt` pulse in the same cycle. The threshold outputs fall one cycle after the counter clears.
- R7: Each high bit of `lt_evt` sets the matching bit of the detect register (address 0x400, bits [CAUSE_W-1:0]). Set bits stay set, and a non-zero write to 0x400 changes nothing.
- R8: A write of zero to 0x400 clears the detect register. Any `lt_evt` bit high in that same cycle is still latched.
- R9: `lt_err` is 1 in the cycle after one in which the detect register ANDed with the enable register (address 0x404, bits [CAUSE_W-1:0]) is non-zero.
- R10: `maint_irq` is 1 in the cycle after one in which some status output is 1 and its control enable is set. The control register is at address 0x15C, with bit 2 for `lt_err`, bit 1 for `port_failed` and bit 0 for `port_degraded`.
- R11: The control, threshold and enable registers read back as written in the fields listed above, with all other bits 0. Any address not listed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (12) | Byte address, word aligned |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Combinational read data for `addr` |
| rate_evt | input | 1 | Link error event pulse |
| lt_evt | input | CAUSE_W (8) | Logical/transport error cause pulses |
| lt_err | output | 1 | Enabled logical/transport error is latched |
| port_failed | output | 1 | Counter reached the failed level |
| port_degraded | output | 1 | Counter reached the degraded level |
| maint_irq | output | 1 | Combined maintenance interrupt |

## Verification
The state of this block is visible at the ports within one or two cycles. A wrong counter value shows up at the next read of 0x408. It also shows up as a threshold output changing one cycle early or late around the programmed level. A detect bit that is lost or stuck shows up both on readback and on `lt_err` one cycle later. A gating error in the interrupt path shows up on `maint_irq` exactly one cycle after the status it depends on. For these reasons, a per-cycle behavioural model that follows counter saturation, clear priority and the same-cycle detect race catches a fault at the first cycle it matters.

// File: rtl/errmon_pkg.sv
package errmon_pkg;
  localparam logic [11:0] OFF_CTRL   = 12'h15C;
  localparam logic [11:0] OFF_THRESH = 12'h36C;
  localparam logic [11:0] OFF_DETECT = 12'h400;
  localparam logic [11:0] OFF_ENABLE = 12'h404;
  localparam logic [11:0] OFF_COUNT  = 12'h408;

  localparam int FAIL_LSB = 24;
  localparam int DEGR_LSB = 16;

  localparam int SRC_DEGR = 0;
  localparam int SRC_FAIL = 1;
  localparam int SRC_LT   = 2;
  localparam int NUM_SRC  = 3;
endpackage

// File: rtl/errmon_cfg.sv
module errmon_cfg #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CAUSE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [errmon_pkg::NUM_SRC-1:0] ctrl_q,
  output logic [CNT_W-1:0]             thr_fail_q,
  output logic [CNT_W-1:0]             thr_degr_q,
  output logic [CAUSE_W-1:0]           enable_q,
  output logic                         det_clr,
  output logic                         cnt_clr
);
  import errmon_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFF_THRESH);
  localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(OFF_DETECT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_COUNT);

  logic ctrl_we, thr_we, en_we;
  logic [NUM_SRC-1:0] ctrl_d;
  logic [CNT_W-1:0]   thr_fail_d, thr_degr_d;
  logic [CAUSE_W-1:0] enable_d;
  logic               unused_wbits;

  assign unused_wbits = ^{wr_data, addr[1:0]};

  // write decode
  always_comb begin
    ctrl_we = wr_en && (addr[ADDR_W-1:2] == A_CTRL[ADDR_W-1:2]);
    thr_we  = wr_en && (addr[ADDR_W-1:2] == A_THR[ADDR_W-1:2]);
    en_we   = wr_en && (addr[ADDR_W-1:2] == A_EN[ADDR_W-1:2]);
    det_clr = wr_en && (addr[ADDR_W-1:2] == A_DET[ADDR_W-1:2]) && (wr_data == '0);
    cnt_clr = wr_en && (addr[ADDR_W-1:2] == A_CNT[ADDR_W-1:2]);
  end

  // next-state values
  always_comb begin
    ctrl_d     = wr_data[NUM_SRC-1:0];
    thr_fail_d = wr_data[FAIL_LSB +: CNT_W];
    thr_degr_d = wr_data[DEGR_LSB +: CNT_W];
    enable_d   = wr_data[CAUSE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      thr_fail_q <= '0;
      thr_degr_q <= '0;
      enable_q   <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (thr_we) begin
        thr_fail_q <= thr_fail_d;
        thr_degr_q <= thr_degr_d;
      end
      if (en_we) enable_q <= enable_d;
    end
  end

  p_ctrl_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_we) |-> $stable(ctrl_q));
  p_en_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_we) |-> $stable(enable_q));
endmodule

// File: rtl/errmon_rate.sv
module errmon_rate #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  input  logic [CNT_W-1:0] thr_fail,
  input  logic [CNT_W-1:0] thr_degr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             failed,
  output logic             degraded
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int NLVL = 2;  // 0: degraded, 1: failed

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] lvl [NLVL];
  logic [NLVL-1:0]  hit_d, hit_q;

  assign lvl[0] = thr_degr;
  assign lvl[1] = thr_fail;

  always_comb begin
    cnt_en = clr || (evt && (cnt_q != CNT_MAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign hit_d[g] = (lvl[g] != '0) && (cnt_q >= lvl[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign degraded = hit_q[0];
  assign failed   = hit_q[1];

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));
  p_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CNT_MAX && !$past(clr)) |-> (cnt_q == CNT_MAX));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (cnt_q == '0));
  p_fail_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> ($past(thr_fail) != '0));
  p_degr_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    degraded |-> ($past(thr_degr) != '0));
endmodule

// File: rtl/errmon_lt_log.sv
module errmon_lt_log #(
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] evt,
  input  logic               clr_zero,
  input  logic [CAUSE_W-1:0] enable,
  output logic [CAUSE_W-1:0] det_q,
  output logic               lt_err
);
  logic [CAUSE_W-1:0] det_d;
  logic               lt_d;

  always_comb begin
    det_d = (clr_zero ? '0 : det_q) | evt;
    lt_d  = |(det_q & enable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q  <= '0;
      lt_err <= 1'b0;
    end else begin
      det_q  <= det_d;
      lt_err <= lt_d;
    end
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(det_q) & ~det_q) != '0) |-> $past(clr_zero));
  p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & $past(evt)) == $past(evt)));
  p_lt_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lt_err |-> ($past(enable) != '0));
endmodule

// File: rtl/errmon_irq.sv
module errmon_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] ctrl,
  output logic            irq
);
  logic [NSRC-1:0] gated;
  logic            irq_d;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign gated[s] = status[s] & ctrl[s];
  end

  assign irq_d = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(status) != '0));
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(ctrl) != '0));
endmodule

// File: rtl/err_thresh_mon.sv
module err_thresh_mon #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               rate_evt,
  input  logic [CAUSE_W-1:0] lt_evt,
  output logic               lt_err,
  output logic               port_failed,
  output logic               port_degraded,
  output logic               maint_irq
);
  import errmon_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFF_THRESH);
  localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(OFF_DETECT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_COUNT);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NUM_SRC-1:0] ctrl_q;
  logic [CNT_W-1:0]   thr_fail, thr_degr, cnt_q;
  logic [CAUSE_W-1:0] enable_q, det_q;
  logic               det_clr, cnt_clr;
  logic [NUM_SRC-1:0] status;

  errmon_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CAUSE_W(CAUSE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .thr_fail_q(thr_fail), .thr_degr_q(thr_degr),
    .enable_q(enable_q), .det_clr(det_clr), .cnt_clr(cnt_clr)
  );

  errmon_rate #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n_s), .evt(rate_evt), .clr(cnt_clr),
    .thr_fail(thr_fail), .thr_degr(thr_degr), .cnt_q(cnt_q),
    .failed(port_failed), .degraded(port_degraded)
  );

  errmon_lt_log #(.CAUSE_W(CAUSE_W)) u_lt (
    .clk(clk), .rst_n(rst_n_s), .evt(lt_evt), .clr_zero(det_clr),
    .enable(enable_q), .det_q(det_q), .lt_err(lt_err)
  );

  always_comb begin
    status           = '0;
    status[SRC_LT]   = lt_err;
    status[SRC_FAIL] = port_failed;
    status[SRC_DEGR] = port_degraded;
  end

  errmon_irq #(.NSRC(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .status(status), .ctrl(ctrl_q), .irq(maint_irq)
  );

  // combinational read mux
  always_comb begin
    rd_data = '0;
    if (addr[ADDR_W-1:2] == A_CTRL[ADDR_W-1:2]) begin
      rd_data[NUM_SRC-1:0] = ctrl_q;
    end else if (addr[ADDR_W-1:2] == A_THR[ADDR_W-1:2]) begin
      rd_data[FAIL_LSB +: CNT_W] = thr_fail;
      rd_data[DEGR_LSB +: CNT_W] = thr_degr;
    end else if (addr[ADDR_W-1:2] == A_DET[ADDR_W-1:2]) begin
      rd_data[CAUSE_W-1:0] = det_q;
    end else if (addr[ADDR_W-1:2] == A_EN[ADDR_W-1:2]) begin
      rd_data[CAUSE_W-1:0] = enable_q;
    end else if (addr[ADDR_W-1:2] == A_CNT[ADDR_W-1:2]) begin
      rd_data[CNT_W-1:0] = cnt_q;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n_s |-> !(lt_err || port_failed || port_degraded || maint_irq));
endmodule

// File: tb/err_thresh_mon_bench.sv
module err_thresh_mon_bench;
  localparam int ADDR_W = 12, DATA_W = 32, CNT_W = 8, CAUSE_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rate_evt = 1'b0;
  logic [CAUSE_W-1:0] lt_evt = '0;
  logic [DATA_W-1:0] rd_data;
  logic lt_err, port_failed, port_degraded, maint_irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  err_thresh_mon #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CAUSE_W(CAUSE_W))
  u_err_thresh_mon (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rate_evt(rate_evt), .lt_evt(lt_evt), .lt_err(lt_err),
    .port_failed(port_failed), .port_degraded(port_degraded), .maint_irq(maint_irq)
  );

  // behavioural reference
  int m_cnt, m_det, m_en, m_ctrl, m_tf, m_td;
  bit m_fail, m_degr, m_lt, m_irq;

  function automatic int m_read(int a);
    case (a)
      'h15C: return m_ctrl;
      'h36C: return (m_tf << 24) | (m_td << 16);
      'h400: return m_det;
      'h404: return m_en;
      'h408: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit n_fail, n_degr, n_lt, n_irq;
    if (!rst_n) begin
      m_cnt = 0; m_det = 0; m_en = 0; m_ctrl = 0; m_tf = 0; m_td = 0;
      m_fail = 0; m_degr = 0; m_lt = 0; m_irq = 0;
    end else begin
      n_fail = (m_tf != 0) && (m_cnt >= m_tf);
      n_degr = (m_td != 0) && (m_cnt >= m_td);
      n_lt   = (m_det & m_en) != 0;
      n_irq  = (m_lt && m_ctrl[2]) || (m_fail && m_ctrl[1]) || (m_degr && m_ctrl[0]);
      if (wr_en && addr == 'h408) m_cnt = 0;
      else if (rate_evt && m_cnt < 255) m_cnt = m_cnt + 1;
      if (wr_en && addr == 'h400 && wr_data == 0) m_det = 0;
      m_det = m_det | int'(lt_evt);
      if (wr_en && addr == 'h15C) m_ctrl = int'(wr_data[2:0]);
      if (wr_en && addr == 'h404) m_en = int'(wr_data[CAUSE_W-1:0]);
      if (wr_en && addr == 'h36C) begin
        m_tf = int'(wr_data[31:24]);
        m_td = int'(wr_data[23:16]);
      end
      m_fail = n_fail; m_degr = n_degr; m_lt = n_lt; m_irq = n_irq;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    cyc++;
    #1;
    if (!done) begin
      chk("R3 port_failed", int'(port_failed), int'(m_fail));
      chk("R4 port_degraded", int'(port_degraded), int'(m_degr));
      chk("R9 lt_err", int'(lt_err), int'(m_lt));
      chk("R10 maint_irq", int'(maint_irq), int'(m_irq));
      chk("R11 rd_data", int'(rd_data), m_read(int'(addr)));
    end
  end

  task automatic step(bit we, int a, int d, bit re, int le);
    @(negedge clk);
    wr_en = we; addr = ADDR_W'(a); wr_data = DATA_W'(d);
    rate_evt = re; lt_evt = CAUSE_W'(le);
  endtask

  task automatic idle(int n, int a);
    for (int i = 0; i < n; i++) step(0, a, 0, 0, 0);
  endtask

  task automatic at_sample();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3, 0);
    at_sample();
    chk("R1 outputs in reset", int'({lt_err, port_failed, port_degraded, maint_irq}), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4, 'h408);
    at_sample();
    chk("R1 count after reset", int'(rd_data), 0);

    // thresholds: failed 5, degraded 3; irq on both
    step(1, 'h36C, 32'h0503_0000, 0, 0);
    step(1, 'h15C, 3, 0, 0);
    idle(1, 'h36C);
    at_sample();
    chk("R11 threshold readback", int'(rd_data), 32'h0503_0000);
    for (int i = 0; i < 3; i++) step(0, 'h408, 0, 1, 0);
    idle(2, 'h408);
    at_sample();
    chk("R4 degraded at level", int'(port_degraded), 1);
    chk("R3 failed below level", int'(port_failed), 0);
    for (int i = 0; i < 2; i++) step(0, 'h408, 0, 1, 0);
    idle(2, 'h408);
    at_sample();
    chk("R3 failed at level", int'(port_failed), 1);
    chk("R10 irq from thresholds", int'(maint_irq), 1);
    chk("R2 count value", int'(rd_data), 5);

    // clear beats same-cycle event
    step(1, 'h408, 0, 1, 0);
    idle(1, 'h408);
    at_sample();
    chk("R6 clear wins", int'(rd_data), 0);
    idle(1, 'h408);
    at_sample();
    chk("R6 failed drops", int'(port_failed), 0);

    // degraded disabled by zero
    step(1, 'h36C, 32'h0200_0000, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 'h408, 0, 1, 0);
    idle(2, 'h408);
    at_sample();
    chk("R5 zero degraded level", int'(port_degraded), 0);
    chk("R3 failed again", int'(port_failed), 1);

    // saturation with both levels off
    step(1, 'h36C, 0, 0, 0);
    for (int i = 0; i < 260; i++) step(0, 'h408, 0, 1, 0);
    idle(2, 'h408);
    at_sample();
    chk("R2 saturates", int'(rd_data), 255);
    chk("R5 zero failed level", int'(port_failed), 0);

    // logical/transport path
    step(1, 'h408, 0, 0, 0);
    step(1, 'h404, 5, 0, 0);
    step(1, 'h15C, 4, 0, 0);
    step(0, 'h400, 0, 0, 2);
    idle(2, 'h400);
    at_sample();
    chk("R7 detect set", int'(rd_data), 2);
    chk("R9 masked cause", int'(lt_err), 0);
    step(0, 'h400, 0, 0, 1);
    idle(2, 'h400);
    at_sample();
    chk("R9 enabled cause", int'(lt_err), 1);
    chk("R10 irq from lt", int'(maint_irq), 1);
    step(1, 'h400, 32'hFF, 0, 0);
    idle(2, 'h400);
    at_sample();
    chk("R7 nonzero write ignored", int'(rd_data), 3);
    step(1, 'h400, 0, 0, 4);
    idle(2, 'h400);
    at_sample();
    chk("R8 event wins over clear", int'(rd_data), 4);
    chk("R9 still set", int'(lt_err), 1);
    step(1, 'h400, 0, 0, 0);
    idle(3, 'h400);
    at_sample();
    chk("R8 clear", int'(rd_data), 0);
    chk("R10 irq drops", int'(maint_irq), 0);

    idle(1, 'h100);
    at_sample();
    chk("R11 unmapped reads zero", int'(rd_data), 0);
    idle(2, 'h100);
    finish_run();
  end
endmodule